// File: doc/BRIEF.md
# Start-of-Transmission Sync Byte Aligner

This block sits behind the deserialiser of one high-speed serial data lane. The lane delivers one unaligned byte-wide word per byte-clock cycle, with the byte clock running at one quarter of the bit clock. The aligner looks for the start-of-transmission sync byte at every bit offset across a two-word sliding window. It then fixes the byte boundary at the offset where the sync was found. From then on it emits one aligned payload byte per incoming word until the high-speed burst ends.

A sync byte received with faults is graded rather than simply rejected. A single flipped bit is tolerated, and the fault is recorded. Damage limited to the two low bits is recorded separately. Anything worse, or a sync that never shows up, causes the burst to be discarded and a multi-bit fault to be recorded. The fault flags are sticky and software clears them bit by bit. A search begins each time the lane-entry tracker raises the HS-active indication, and all alignment state is dropped when that indication falls.

The lane cannot be stalled, so neither side has a ready signal. Every word presented with `in_valid` while `hs_active` is high is consumed in that cycle. Every cycle in which `out_valid` is high carries a byte that the consumer must take at once.

Top module: `sot_byte_aligner`

## Requirements
- R1: After reset, `out_valid` is 0 and `err_flags` is 3'b000.
- R2: Bit 0 of each input word is the earliest bit on the wire. The sync byte is found at any of the 8 bit offsets. The bytes that follow it are output at that same boundary, and the sync byte itself is never output.
- R3: The sync byte has value 8'hB8, which is the wire sequence 0,0,0,1,1,1,0,1 in time order.
- R4: Within one window, an exact sync match at any offset is chosen over a one-bit-error match at a lower offset.
- R5: A sync candidate with exactly one wrong bit is accepted for alignment and sets `err_flags[0]` (single-bit fault).
- R6: A fault confined to bits [1:0] of the sync byte sets `err_flags[2]`. If one of those bits is wrong, the candidate is accepted and `err_flags[0]` is also set. If both are wrong, no exact match is in the window, and that candidate is preferred over any one-bit match, then the burst is discarded and `err_flags[1]` is also set.
- R7: If no acceptable sync is found in the first 4 valid words of a burst, the block sets `err_flags[1]` (multi-bit fault) and outputs nothing until `hs_active` falls and rises again.
- R8: When `hs_active` is low, no byte is output from the next clock edge onward, and the found boundary and the previous word are cleared. The next burst searches afresh and may align at a different offset.
- R9: Each flag in `err_flags` stays set until a cycle in which the matching bit of `err_clr` is 1. Clearing one bit leaves the others unchanged.
- R10: Each aligned byte appears on `out_data` with `out_valid` high in the cycle after the edge that accepted the word completing it. Cycles with `in_valid` low produce no output and do not move the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_active | input | 1 | High while the lane is in a high-speed burst |
| in_valid | input | 1 | `in_word` carries a new unaligned word |
| in_word | input | 8 | Unaligned lane word, bit 0 earliest |
| out_valid | output | 1 | `out_data` carries an aligned payload byte |
| out_data | output | 8 | Aligned payload byte |
| err_flags | output | 3 | Sticky faults: [0] single-bit, [1] multi-bit, [2] low-pair |
| err_clr | input | 3 | Write-one-to-clear, per flag bit |

## Verification
The aligner is driven with bursts whose sync lands at each of the eight bit offsets behind a zero preamble. These show whether the boundary tracks the offset and whether the sync byte stays out of the stream. A crafted prefix places a one-bit near-match below an exact match in the same window, which separates exact-first selection from lowest-offset selection. Corrupted syncs with a high bit, one low bit, or both low bits flipped tell apart the three fault grades and the accept-or-discard outcome. Bursts with idle gaps, a sync arriving too late, and a burst cut short before a re-aligned burst at a new offset cover the gap, timeout and teardown rules.

// File: rtl/sot_align_pkg.sv
package sot_align_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_LOCK,
    ST_DROP
  } lane_state_e;

  localparam int ERR_BITS  = 3;
  localparam int ERR_ONE   = 0;
  localparam int ERR_MULTI = 1;
  localparam int ERR_LSB   = 2;
endpackage

// File: rtl/sot_window_scan.sv
// Grades every bit offset of a two-word window against the sync byte.
module sot_window_scan #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC = 8'hB8,
  parameter int OFF_W = $clog2(BYTE_W)
) (
  input  logic [2*BYTE_W-1:0] win,
  output logic                accept,
  output logic [OFF_W-1:0]    accept_off,
  output logic                accept_one,
  output logic                accept_lsb,
  output logic                reject_pair
);
  localparam logic [BYTE_W-1:0] PAIR_MASK = BYTE_W'(3);

  logic [BYTE_W-1:0] exact_v;
  logic [BYTE_W-1:0] one_v;
  logic [BYTE_W-1:0] pair_v;
  logic [BYTE_W-1:0] lsb_v;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_off
    logic [BYTE_W-1:0] diff;
    assign diff       = win[k +: BYTE_W] ^ SYNC;
    assign exact_v[k] = (diff == '0);
    assign one_v[k]   = ($countones(diff) == 1);
    assign pair_v[k]  = (diff == PAIR_MASK);
    assign lsb_v[k]   = (diff[1:0] != 2'b00) && (diff[BYTE_W-1:2] == '0);
  end

  logic [OFF_W-1:0] ex_off;
  logic [OFF_W-1:0] one_off;

  always_comb begin
    ex_off  = '0;
    one_off = '0;
    for (int k = BYTE_W - 1; k >= 0; k--) begin
      if (exact_v[k]) ex_off = OFF_W'(k);
      if (one_v[k])   one_off = OFF_W'(k);
    end
  end

  always_comb begin
    accept      = 1'b0;
    accept_off  = '0;
    accept_one  = 1'b0;
    accept_lsb  = 1'b0;
    reject_pair = 1'b0;
    if (|exact_v) begin
      accept     = 1'b1;
      accept_off = ex_off;
    end else if (|pair_v) begin
      reject_pair = 1'b1;
    end else if (|one_v) begin
      accept     = 1'b1;
      accept_off = one_off;
      accept_one = 1'b1;
      accept_lsb = lsb_v[one_off];
    end
  end
endmodule

// File: rtl/sot_search_ctrl.sv
// Burst state machine: search with word budget, lock, or drop.
module sot_search_ctrl
  import sot_align_pkg::*;
#(
  parameter int SEARCH_LIMIT = 4,
  parameter int OFF_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_active,
  input  logic                take,
  input  logic                accept,
  input  logic [OFF_W-1:0]    accept_off,
  input  logic                accept_one,
  input  logic                accept_lsb,
  input  logic                reject_pair,
  output logic                emit,
  output logic [OFF_W-1:0]    lock_off,
  output logic [ERR_BITS-1:0] err_set
);
  localparam int CNT_W = $clog2(SEARCH_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(SEARCH_LIMIT - 1);

  lane_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0] off_q, off_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    off_d   = off_q;
    err_set = '0;
    if (!hs_active) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      off_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_SEARCH: begin
          state_d = ST_SEARCH;
          if (take) begin
            if (accept) begin
              state_d          = ST_LOCK;
              off_d            = accept_off;
              err_set[ERR_ONE] = accept_one;
              err_set[ERR_LSB] = accept_lsb;
            end else if (reject_pair) begin
              state_d            = ST_DROP;
              err_set[ERR_MULTI] = 1'b1;
              err_set[ERR_LSB]   = 1'b1;
            end else if (cnt_q == LAST_WORD) begin
              state_d            = ST_DROP;
              err_set[ERR_MULTI] = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_LOCK: state_d = ST_LOCK;
        ST_DROP: state_d = ST_DROP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      off_q   <= off_d;
    end
  end

  assign emit     = (state_q == ST_LOCK) && take;
  assign lock_off = off_q;
endmodule

// File: rtl/sot_byte_extract.sv
// Holds the previous word and slices aligned bytes from the window.
module sot_byte_extract #(
  parameter int BYTE_W = 8,
  parameter int OFF_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_active,
  input  logic                take,
  input  logic                emit,
  input  logic [BYTE_W-1:0]   in_word,
  input  logic [OFF_W-1:0]    off,
  output logic [2*BYTE_W-1:0] win,
  output logic                out_valid,
  output logic [BYTE_W-1:0]   out_data
);
  logic [BYTE_W-1:0] prev_q;

  assign win = {in_word, prev_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (!hs_active)  prev_q <= '0;
      else if (take)   prev_q <= in_word;
      out_valid <= emit;
      if (emit) out_data <= win[off +: BYTE_W];
    end
  end
endmodule

// File: rtl/sot_err_sticky.sv
// Sticky fault bits with per-bit write-one-to-clear; a new set wins.
module sot_err_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/sot_byte_aligner.sv
module sot_byte_aligner
  import sot_align_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'hB8,
  parameter int SEARCH_LIMIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_active,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_word,
  output logic                out_valid,
  output logic [BYTE_W-1:0]   out_data,
  output logic [ERR_BITS-1:0] err_flags,
  input  logic [ERR_BITS-1:0] err_clr
);
  localparam int OFF_W = $clog2(BYTE_W);

  logic                take;
  logic [2*BYTE_W-1:0] win;
  logic                accept, accept_one, accept_lsb, reject_pair, emit;
  logic [OFF_W-1:0]    accept_off, lock_off;
  logic [ERR_BITS-1:0] err_set;

  assign take = hs_active && in_valid;

  sot_window_scan #(.BYTE_W(BYTE_W), .SYNC(SYNC_PATTERN), .OFF_W(OFF_W)) scan_i (
    .win(win), .accept(accept), .accept_off(accept_off),
    .accept_one(accept_one), .accept_lsb(accept_lsb), .reject_pair(reject_pair)
  );

  sot_search_ctrl #(.SEARCH_LIMIT(SEARCH_LIMIT), .OFF_W(OFF_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .take(take),
    .accept(accept), .accept_off(accept_off), .accept_one(accept_one),
    .accept_lsb(accept_lsb), .reject_pair(reject_pair),
    .emit(emit), .lock_off(lock_off), .err_set(err_set)
  );

  sot_byte_extract #(.BYTE_W(BYTE_W), .OFF_W(OFF_W)) extract_i (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .take(take), .emit(emit),
    .in_word(in_word), .off(lock_off), .win(win),
    .out_valid(out_valid), .out_data(out_data)
  );

  sot_err_sticky #(.N(ERR_BITS)) flags_i (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flags(err_flags)
  );
endmodule

// File: rtl/sot_byte_aligner_chk.sv
module sot_byte_aligner_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_active,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ERR_W-1:0] err_flags,
  input logic [ERR_W-1:0] err_clr
);
  AST_OUT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(hs_active && in_valid)); // R10

  AST_HS_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_active |=> !out_valid); // R8

  AST_SYNC_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> !out_valid); // R2

  AST_DISCARD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[1]) |-> !out_valid); // R7

  for (genvar i = 0; i < ERR_W; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flags[i] && !err_clr[i]) |=> err_flags[i]); // R9
  end
endmodule

bind sot_byte_aligner sot_byte_aligner_chk #(.ERR_W(3)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .in_valid(in_valid),
  .out_valid(out_valid), .err_flags(err_flags), .err_clr(err_clr)
);

// File: tb/sot_byte_aligner_tb_top.sv
module sot_byte_aligner_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_active = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_word = 8'h00;
  logic [2:0] err_clr = 3'b000;
  logic       out_valid;
  logic [7:0] out_data;
  logic [2:0] err_flags;

  always #5 clk = ~clk;

  sot_byte_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .in_valid(in_valid),
    .in_word(in_word), .out_valid(out_valid), .out_data(out_data),
    .err_flags(err_flags), .err_clr(err_clr)
  );

  int n_chk = 0;
  int n_err = 0;

  logic       stream [0:511];
  int         nbits;
  logic [7:0] exp_b [0:63];
  int         exp_outs;
  logic [7:0] cap [0:1023];
  int         cap_n = 0;
  int         base;

  always @(posedge clk) begin
    #1;
    if (out_valid === 1'b1) begin
      if (cap_n < 1024) cap[cap_n] = out_data;
      cap_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input logic [63:0] pre, input int pre_n, input logic [7:0] sync,
                           input int pay_n, input bit zero_pay, input bit gaps,
                           input int stop_words);
    int nw;
    int sent;
    nbits = 0;
    for (int i = 0; i < pre_n; i++) begin stream[nbits] = pre[i]; nbits++; end
    for (int i = 0; i < 8; i++) begin stream[nbits] = sync[i]; nbits++; end
    for (int m = 0; m < pay_n; m++) begin
      exp_b[m] = zero_pay ? 8'h00 : 8'((m * 73 + 17) & 255);
      for (int i = 0; i < 8; i++) begin stream[nbits] = exp_b[m][i]; nbits++; end
    end
    nw = (nbits + 7) / 8 + 1;
    sent = (stop_words > 0) ? stop_words : nw;
    exp_outs = sent - (pre_n / 8 + 1) - 1;
    @(negedge clk);
    base = cap_n;
    hs_active = 1'b1;
    for (int w = 0; w < sent; w++) begin
      logic [7:0] wv;
      if (gaps && (w % 3 == 1)) begin
        in_valid = 1'b0;
        in_word  = 8'hFF;
        @(negedge clk);
      end
      for (int b = 0; b < 8; b++) wv[b] = (8 * w + b < nbits) ? stream[8 * w + b] : 1'b0;
      in_valid = 1'b1;
      in_word  = wv;
      @(negedge clk);
    end
    in_valid  = 1'b0;
    hs_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_payload(input string req, input int n);
    for (int i = 0; i < n; i++) chk(req, int'(cap[base + i]), int'(exp_b[i]));
  endtask

  task automatic clear_flags(input logic [2:0] mask);
    @(negedge clk);
    err_clr = mask;
    @(negedge clk);
    err_clr = 3'b000;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 err_flags", int'(err_flags), 0);
  endtask

  task automatic t_offsets;
    for (int k = 0; k < 8; k++) begin
      run_burst(64'h0, 8 + k, 8'hB8, 6, 1'b0, 1'b0, 0);
      chk("R10 byte count per offset", cap_n - base, exp_outs);
      check_payload("R2 R3 payload at offset", 6);
      chk("R2 no fault on exact sync", int'(err_flags), 0);
    end
  endtask

  task automatic t_gaps;
    run_burst(64'h0, 19, 8'hB8, 8, 1'b0, 1'b1, 0);
    chk("R10 count with gaps", cap_n - base, exp_outs);
    check_payload("R10 payload with gaps", 8);
  endtask

  task automatic t_prefer;
    // bits 0,0,0,1,1,1 before sync: offset 0 is a one-bit match, offset 6 exact
    run_burst(64'h38, 6, 8'hB8, 6, 1'b0, 1'b0, 0);
    check_payload("R4 exact wins", 6);
    chk("R4 no single-bit flag", int'(err_flags), 0);
  endtask

  task automatic t_single;
    run_burst(64'h0, 13, 8'hB8 ^ 8'h20, 6, 1'b0, 1'b0, 0);
    check_payload("R5 payload after one-bit sync", 6);
    chk("R5 flags", int'(err_flags), 3'b001);
    clear_flags(3'b001);
    chk("R9 clear single", int'(err_flags), 0);
  endtask

  task automatic t_lsb_one;
    run_burst(64'h0, 13, 8'hB9, 6, 1'b0, 1'b0, 0);
    check_payload("R6 payload after low-bit fault", 6);
    chk("R6 flags single+low", int'(err_flags), 3'b101);
    clear_flags(3'b100);
    chk("R9 per-bit clear keeps bit0", int'(err_flags), 3'b001);
    clear_flags(3'b001);
    chk("R9 all clear", int'(err_flags), 0);
  endtask

  task automatic t_lsb_pair;
    run_burst(64'h0, 13, 8'hBB, 6, 1'b1, 1'b0, 0);
    chk("R6 pair fault discards", cap_n - base, 0);
    chk("R6 flags multi+low", int'(err_flags), 3'b110);
    clear_flags(3'b110);
    chk("R9 cleared", int'(err_flags), 0);
  endtask

  task automatic t_timeout;
    run_burst(64'h0, 40, 8'hB8, 6, 1'b0, 1'b0, 0);
    chk("R7 late sync gives nothing", cap_n - base, 0);
    chk("R7 multi-bit flag", int'(err_flags), 3'b010);
    run_burst(64'h0, 10, 8'hB8, 6, 1'b0, 1'b0, 0);
    check_payload("R8 next burst realigns", 6);
    chk("R9 flag held across bursts", int'(err_flags), 3'b010);
    clear_flags(3'b010);
  endtask

  task automatic t_hs_drop;
    int after;
    run_burst(64'h0, 21, 8'hB8, 10, 1'b0, 1'b0, 5);
    chk("R8 bytes before drop", cap_n - base, 1);
    chk("R8 first byte", int'(cap[base]), int'(exp_b[0]));
    after = cap_n;
    repeat (4) @(negedge clk);
    chk("R8 silent while low", cap_n - after, 0);
    chk("R8 out_valid low", int'(out_valid), 0);
    run_burst(64'h0, 12, 8'hB8, 7, 1'b0, 1'b0, 0);
    chk("R8 count after new offset", cap_n - base, exp_outs);
    check_payload("R8 payload after new offset", 7);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_offsets();
    t_gaps();
    t_prefer();
    t_single();
    t_lsb_one();
    t_lsb_pair();
    t_timeout();
    t_hs_drop();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule